// File: doc/BRIEF.md
# Coherent Byte-Read Timer Counter

This block is a 16-bit free-running up-counter that software reaches over an 8-bit register port. The counter advances on ticks from one of three sources: the bus clock itself, a fixed-rate enable strobe, or an asynchronous external clock. The external clock is brought into the bus-clock domain first. The selected tick then passes through a power-of-two prescaler with a ratio from 1 to 128. A control byte sets the source and the ratio.

Because the counter is wider than the bus, software reads it in two byte accesses. The first read of either byte copies the full 16-bit count into a holding register. Later reads are served from that copy until the opposite byte has been read, so both bytes always come from the same instant. This works in either byte order. A write to a counter byte clears the counter. A write to either a counter byte or the control byte abandons any half-finished coherent read.

Top module: `coherent_tick_counter`

## Requirements
- R1: Reset sets the counter to 0x0000, the control byte to 0x00 and the holding state to empty, so that a read at address 0, 1 or 2 returns 0x00.
- R2: When nothing is held, a read at address 1 (high byte) or at address 2 (low byte) returns the live count byte and copies all 16 counter bits into the holding register. Further reads of that same byte return held data. The next read of the other byte returns held data and empties the holding register. This works for both orders, high then low and low then high.
- R3: A write to address 0 empties the holding register. The next counter read is then served live and starts a new capture.
- R4: A write of any data to address 1 or 2 sets the counter to zero, clears the prescaler and empties the holding register. The written data is ignored. If a tick arrives in the same cycle, the write wins and the counter reads zero afterwards.
- R5: Control bits [4:3] select the count source: 00 stops the counter, 01 counts every bus-clock cycle, 10 counts each cycle in which fixed_en is high, and 11 counts external clock rising edges.
- R6: ext_clk is synchronised through two flops. Each rising edge then gives exactly one single-cycle count enable.
- R7: Control bits [2:0] hold a code P. The counter advances once per 2^P source ticks (1, 2, 4, ..., 128). A newly written P takes effect from the cycle after the write.
- R8: The counter wraps from 0xFFFF to 0x0000 and never moves by more than one per cycle.
- R9: Address 0 reads back the whole control byte last written. Bits [7:5] have no effect. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 control, 1 count high, 2 count low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe for one cycle; drives the holding side effects |
| rd_data | output | 8 | Read data for addr, combinational |
| ext_clk | input | 1 | Asynchronous external count clock |
| fixed_en | input | 1 | Fixed-rate count enable, synchronous to clk |

## Verification
Two events can land in the same cycle: a counter-clearing write and a prescaled count tick. The bench forces the overlap by selecting the bus clock with a ratio of 1, so that every cycle carries a tick, and then writing a counter byte with nonzero data. Both bytes are read straight afterwards. Zero shows that the write took priority and that its data was discarded. A non-zero result shows that the tick slipped through.

// File: rtl/coherent_tick_counter.sv
module coherent_tick_counter #(
  parameter int DW   = 8,
  parameter int PSW  = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          ext_clk,
  input  logic          fixed_en
);
  localparam int CW = 2 * DW;
  localparam int PW = (1 << PSW) - 1;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HI   = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;

  logic [DW-1:0]  ctrl;
  logic [CW-1:0]  cnt, hold, view;
  logic           latched, first_hi;
  logic [PW-1:0]  pre, mask;
  logic [SYNC:0]  ext_sr;
  logic           src_tick;

  wire [1:0]     sel      = ctrl[PSW+1:PSW];
  wire [PSW-1:0] ps       = ctrl[PSW-1:0];
  wire           ctrl_wr  = wr_en && (addr == A_CTRL);
  wire           cnt_wr   = wr_en && (addr == A_HI || addr == A_LO);
  wire           cnt_rd   = rd_en && (addr == A_HI || addr == A_LO);
  wire           ext_tick = ext_sr[SYNC-1] & ~ext_sr[SYNC];
  wire           div_tick = src_tick && ((pre & mask) == mask);

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (i < int'(ps));
  end

  always_comb begin
    case (sel)
      2'b01:   src_tick = 1'b1;
      2'b10:   src_tick = fixed_en;
      2'b11:   src_tick = ext_tick;
      default: src_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sr <= '0;
    else        ext_sr <= {ext_sr[SYNC-1:0], ext_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (cnt_wr) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      if (src_tick) pre <= pre + PW'(1);
      if (div_tick) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched  <= 1'b0;
      first_hi <= 1'b0;
      hold     <= '0;
    end else if (ctrl_wr || cnt_wr) begin
      latched  <= 1'b0;
    end else if (cnt_rd) begin
      if (!latched) begin
        latched  <= 1'b1;
        first_hi <= (addr == A_HI);
        hold     <= cnt;
      end else if ((addr == A_HI) != first_hi) begin
        latched  <= 1'b0;
      end
    end
  end

  assign view = latched ? hold : cnt;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = ctrl;
      A_HI:    rd_data = view[CW-1:DW];
      A_LO:    rd_data = view[DW-1:0];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/coherent_tick_counter_chk.sv
module coherent_tick_counter_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    addr,
  input logic [1:0]    sel,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] hold,
  input logic          latched,
  input logic          first_hi,
  input logic          cnt_wr,
  input logic          ctrl_wr,
  input logic          cnt_rd,
  input logic          ext_tick
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!latched && cnt_rd && !cnt_wr && !ctrl_wr) |=> (latched && hold == $past(cnt)));

  assert_same_byte_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && cnt_rd && ((addr == 2'd1) == first_hi) && !cnt_wr && !ctrl_wr)
    |=> (latched && $stable(hold)));

  assert_ctrl_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !latched);

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == '0 && !latched));

  assert_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && !cnt_wr) |=> $stable(cnt));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1)));
endmodule

bind coherent_tick_counter coherent_tick_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .sel(sel), .cnt(cnt), .hold(hold),
  .latched(latched), .first_hi(first_hi), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr),
  .cnt_rd(cnt_rd), .ext_tick(ext_tick)
);

// File: tb/sim_coherent_tick_counter.sv
`timescale 1ns/1ps
module sim_coherent_tick_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       ext_clk = 1'b0;
  logic       fixed_en = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  coherent_tick_counter u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ext_clk(ext_clk), .fixed_en(fixed_en)
  );

  // prescale code, cycles waited, expected count
  localparam int VEC [8][3] = '{
    '{0, 300, 300}, '{1, 300, 150}, '{2, 300, 75}, '{3, 300, 37},
    '{4, 300, 18},  '{5, 300, 9},   '{6, 300, 4},  '{7, 300, 2}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic rd16(input bit hi_first, output logic [15:0] v);
    logic [7:0] h, l;
    if (hi_first) begin bus_rd(2'd1, h); bus_rd(2'd2, l); end
    else          begin bus_rd(2'd2, l); bus_rd(2'd1, h); end
    v = {h, l};
  endtask

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    bus_rd(2'd0, b); chk("R1 ctrl", b, 8'h00);
    bus_rd(2'd1, b); chk("R1 high", b, 8'h00);
    bus_rd(2'd2, b); chk("R1 low", b, 8'h00);

    // R7 R2 table: bus clock, every prescale, alternating read order
    for (int i = 0; i < 8; i++) begin
      bus_wr(2'd0, 8'h08 | 8'(VEC[i][0]));
      bus_wr(2'd2, 8'h00);
      repeat (VEC[i][1]) @(posedge clk);
      rd16(i[0] == 1'b0, v);
      chk("R7 R2 high", v[15:8], 8'(VEC[i][2] >> 8));
      chk("R7 R2 low", v[7:0], 8'(VEC[i][2]));
    end

    // R9 control readback, unused bits
    bus_wr(2'd0, 8'hE8);
    bus_rd(2'd0, b); chk("R9 ctrl readback", b, 8'hE8);
    bus_rd(2'd3, b); chk("R9 addr3", b, 8'h00);

    // R4 write collides with tick, data ignored
    bus_wr(2'd1, 8'hA5);
    rd16(1'b1, v);
    chk("R4 clear high", v[15:8], 8'h00);
    chk("R4 clear low", v[7:0], 8'h00);

    // R2 repeated high read stays held
    bus_wr(2'd1, 8'h00);
    repeat (700) @(posedge clk);
    bus_rd(2'd1, b); chk("R2 first high", b, 8'h02);
    repeat (10) @(posedge clk);
    bus_rd(2'd1, b); chk("R2 repeat high", b, 8'h02);
    bus_rd(2'd2, b); chk("R2 held low", b, 8'hBC);

    // R3 control write between byte reads
    bus_wr(2'd2, 8'h00);
    repeat (300) @(posedge clk);
    bus_rd(2'd2, b); chk("R3 first low", b, 8'h2C);
    bus_wr(2'd0, 8'h08);
    bus_rd(2'd1, b); chk("R3 fresh high", b, 8'h01);
    bus_rd(2'd2, b); chk("R3 new capture low", b, 8'h2E);

    // R4 counter write between byte reads
    bus_wr(2'd2, 8'h00);
    repeat (300) @(posedge clk);
    bus_rd(2'd1, b); chk("R4 first high", b, 8'h01);
    bus_wr(2'd2, 8'h77);
    bus_rd(2'd2, b); chk("R4 live low after clear", b, 8'h00);
    bus_rd(2'd1, b);

    // R5 stopped
    bus_wr(2'd0, 8'h00);
    bus_wr(2'd2, 8'h00);
    repeat (20) @(posedge clk);
    rd16(1'b0, v); chk("R5 stopped", v[7:0], 8'h00);

    // R5 fixed enable
    bus_wr(2'd0, 8'h10);
    bus_wr(2'd2, 8'h00);
    repeat (10) @(posedge clk);
    rd16(1'b1, v); chk("R5 fixed idle", v[7:0], 8'h00);
    @(negedge clk); fixed_en = 1'b1;
    repeat (5) @(negedge clk); fixed_en = 1'b0;
    rd16(1'b0, v); chk("R5 fixed count", v[7:0], 8'h05);

    // R6 external edges
    bus_wr(2'd0, 8'h18);
    bus_wr(2'd2, 8'h00);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk); ext_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (5) @(posedge clk);
    rd16(1'b1, v);
    chk("R6 ext high", v[15:8], 8'h00);
    chk("R6 ext low", v[7:0], 8'h06);

    // R8 wrap
    bus_wr(2'd0, 8'h08);
    bus_wr(2'd2, 8'h00);
    repeat (65539) @(posedge clk);
    rd16(1'b0, v);
    chk("R8 wrap high", v[15:8], 8'h00);
    chk("R8 wrap low", v[7:0], 8'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule